// File: doc/BRIEF.md
# System tick down-counter timer

A periodic down-counter with a width of 24 bits. Software programs it through four word registers on a simple request/response bus. On each tick it counts down. When it passes from one to zero it raises a sticky expiry flag and can emit a one-cycle interrupt pulse. On the following tick it reloads, so one period lasts reload+1 ticks.

Ticks come from one of two sources. The first is every cycle of the core clock. The second is a single-cycle strobe that marks edges of a slower reference clock, synchronised into the core domain. A reload value of zero parks the counter at zero after its next expiry, and the enable bit stays set while it is parked.

Every bus access carries an unprivileged attribute. An unprivileged access is refused with an error response and has no effect. A build parameter states whether the reference strobe exists at all. When it does not, the core clock is always the tick source and the calibration word reports that no reference exists.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0, apart from bit 2 in a build without a reference. The reload word (0x4) and the count word (0x8) read 0, and `irq` is low.
- R2: The control word uses bit 0 for enable, bit 1 for interrupt enable, bit 2 for source select (1 selects the core clock) and bit 16 for the expiry flag. A write changes only bits 2..0.
- R3: With select at 1 the counter ticks on every cycle. With select at 0 it ticks only in cycles where `ref_tick` is high.
- R4: On a tick while running, a count of 0 loads the reload value and does not raise the flag, and any other count above 1 decreases by one, so a period spans reload+1 ticks.
- R5: The tick that takes the count from 1 to 0 sets the flag. If interrupt enable is 1 it also drives `irq` high for exactly one cycle, and if interrupt enable is 0 `irq` stays low.
- R6: A privileged read of the control word returns the flag and then clears it. An expiry in the same cycle as that read leaves the flag set.
- R7: A write to the reload word keeps data bits 23..0 and drops the rest. A read returns the stored value zero-extended.
- R8: Any privileged write to the count word sets the count to 0 and clears the flag. This wins over a tick in the same cycle, so that tick raises neither the flag nor `irq`.
- R9: An expiry that happens while the reload value is 0 stops the counter, and enable still reads 1. Counting resumes only after enable is written to 0 and then to 1.
- R10: In a build without a reference, select reads 1 from reset and a write of 0 to bit 2 leaves it at 1.
- R11: The calibration word (0xC) is read-only. With a reference it reads {0, skew bit, 6'b0, ten-ms count minus one}. Without one it reads 0x8000_0000.
- R12: A request with `req_user` high gets `rsp_err` high and `rsp_rdata` 0, and changes no register.
- R13: A read of an unmapped offset returns 0 without error, and a write to one has no effect.
- R14: A single control write that sets enable and changes select makes the new source drive counting from the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference-clock edge |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Unprivileged access attribute |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the request cycle |
| rsp_err | output | 1 | Error response, valid in the request cycle |
| irq | output | 1 | One-cycle expiry interrupt pulse |

## Verification
Two pairs of functions can land on the same clock edge. The first is expiry against the read that clears the flag. The second is expiry against a write to the count word. The bench steers the count to 1 using reference strobes, then issues the read or the write in the cycle that carries the final strobe. It judges the outcome through the value the read returns, through `irq` on the next cycle, and through a follow-up read of the control word. For the read, the expiry must survive. For the write, the write must cancel it.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned OFS_CTRL = 32'h0;
    localparam int unsigned OFS_LOAD = 32'h4;
    localparam int unsigned OFS_CUR  = 32'h8;
    localparam int unsigned OFS_CAL  = 32'hC;

    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_INT  = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    // decoded, privileged bus actions handed to the counter core
    typedef struct packed {
        logic wr_ctrl;
        logic wr_load;
        logic wr_cur;
        logic rd_ctrl;
    } bus_cmd_t;

endpackage

// File: rtl/tick_bus_port.sv
module tick_bus_port
    import tick_timer_pkg::*;
#(
    parameter int unsigned   ADDR_W   = 8,
    parameter int unsigned   CNT_W    = 24,
    parameter logic [31:0]   CAL_WORD = 32'h0
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              st_en,
    input  logic              st_int,
    input  logic              st_src,
    input  logic              st_flag,
    input  logic [CNT_W-1:0]  st_cnt,
    input  logic [CNT_W-1:0]  st_load,
    output bus_cmd_t          cmd,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);

    logic ok, hit_ctrl, hit_load, hit_cur, hit_cal;
    logic [31:0] ctrl_word;

    always_comb begin
        ok       = req_valid && !req_user;
        hit_ctrl = (req_addr == ADDR_W'(OFS_CTRL));
        hit_load = (req_addr == ADDR_W'(OFS_LOAD));
        hit_cur  = (req_addr == ADDR_W'(OFS_CUR));
        hit_cal  = (req_addr == ADDR_W'(OFS_CAL));

        ctrl_word           = '0;
        ctrl_word[BIT_EN]   = st_en;
        ctrl_word[BIT_INT]  = st_int;
        ctrl_word[BIT_SRC]  = st_src;
        ctrl_word[BIT_FLAG] = st_flag;

        cmd.wr_ctrl = ok && req_write && hit_ctrl;
        cmd.wr_load = ok && req_write && hit_load;
        cmd.wr_cur  = ok && req_write && hit_cur;
        cmd.rd_ctrl = ok && !req_write && hit_ctrl;

        rsp_err   = req_valid && req_user;
        rsp_rdata = '0;
        if (ok && !req_write) begin
            if (hit_ctrl)      rsp_rdata = ctrl_word;
            else if (hit_load) rsp_rdata = 32'(st_load);
            else if (hit_cur)  rsp_rdata = 32'(st_cnt);
            else if (hit_cal)  rsp_rdata = CAL_WORD;
        end
    end

endmodule

// File: rtl/tick_down_core.sv
module tick_down_core
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W   = 24,
    parameter bit          HAS_REF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  bus_cmd_t         cmd,
    input  logic [CNT_W-1:0] wdata,
    output logic             st_en,
    output logic             st_int,
    output logic             st_src,
    output logic             st_flag,
    output logic [CNT_W-1:0] st_cnt,
    output logic [CNT_W-1:0] st_load,
    output logic             irq
);

    typedef struct packed {
        logic             en;
        logic             ien;
        logic             src;
        logic             flag;
        logic             run;
        logic             irq;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] load;
    } state_t;

    localparam logic SRC_RESET = !HAS_REF;

    state_t st_q, st_d;
    logic   tick, expire;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        tick     = st_q.src || ref_tick;
        expire   = 1'b0;

        if (st_q.en && st_q.run && tick) begin
            if (st_q.cnt == CNT_W'(1)) begin
                expire    = 1'b1;
                st_d.cnt  = '0;
                st_d.flag = 1'b1;
                st_d.irq  = st_q.ien;
                if (st_q.load == '0) st_d.run = 1'b0;
            end else if (st_q.cnt == '0) begin
                st_d.cnt = st_q.load;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        // a read clears the flag unless a fresh expiry lands in the same cycle
        if (cmd.rd_ctrl) st_d.flag = expire;

        if (cmd.wr_load) st_d.load = wdata;

        if (cmd.wr_ctrl) begin
            st_d.en  = wdata[BIT_EN];
            st_d.ien = wdata[BIT_INT];
            st_d.src = wdata[BIT_SRC] || !HAS_REF;
            if (wdata[BIT_EN] && !st_q.en) st_d.run = 1'b1;
            if (!wdata[BIT_EN])            st_d.run = 1'b0;
        end

        if (cmd.wr_cur) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
            st_d.irq  = 1'b0;
            if (st_q.load == '0) st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.src  <= SRC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_en   = st_q.en;
    assign st_int  = st_q.ien;
    assign st_src  = st_q.src;
    assign st_flag = st_q.flag;
    assign st_cnt  = st_q.cnt;
    assign st_load = st_q.load;
    assign irq     = st_q.irq;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 24,
    parameter bit          HAS_REF   = 1'b1,
    parameter bit          CAL_SKEW  = 1'b0,
    parameter logic [23:0] CAL_TENMS = 24'd99_999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              irq
);

    localparam logic [31:0] CAL_WORD = HAS_REF ? {1'b0, CAL_SKEW, 6'b0, CAL_TENMS}
                                               : 32'h8000_0000;

    bus_cmd_t         cmd;
    logic             en_w, ien_w, src_w, flag_w;
    logic [CNT_W-1:0] cnt_w, load_w;
    logic             unused_wdata;

    assign unused_wdata = ^req_wdata;

    tick_bus_port #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .CAL_WORD(CAL_WORD)
    ) u_port (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_user (req_user),
        .req_addr (req_addr),
        .st_en    (en_w),
        .st_int   (ien_w),
        .st_src   (src_w),
        .st_flag  (flag_w),
        .st_cnt   (cnt_w),
        .st_load  (load_w),
        .cmd      (cmd),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err)
    );

    tick_down_core #(
        .CNT_W  (CNT_W),
        .HAS_REF(HAS_REF)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .cmd     (cmd),
        .wdata   (req_wdata[CNT_W-1:0]),
        .st_en   (en_w),
        .st_int  (ien_w),
        .st_src  (src_w),
        .st_flag (flag_w),
        .st_cnt  (cnt_w),
        .st_load (load_w),
        .irq     (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_user,
    input logic             irq,
    input logic             flag,
    input logic             en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load
);

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);                                                       // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                       // R5

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1 || cnt == '0)); // R4

    AST_ZERO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && load == '0) |=> (cnt == '0));                          // R9

    AST_USER_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user) |=> ($stable(load) && $stable(en)));         // R12

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_user (req_user),
    .irq      (irq),
    .flag     (flag_w),
    .en       (en_w),
    .cnt      (cnt_w),
    .load     (load_w)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        rv = 1'b0, rw = 1'b0, ru = 1'b0;
    logic [7:0]  ra = '0;
    logic [31:0] rwd = '0;
    logic [31:0] rdat;
    logic        rerr, irq;

    logic        nv = 1'b0, nw = 1'b0;
    logic [7:0]  na = '0;
    logic [31:0] nwd = '0;
    logic [31:0] ndat;
    logic        nerr_o, nirq;

    int nchk = 0, nerr = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .req_valid(rv), .req_write(rw), .req_user(ru), .req_addr(ra), .req_wdata(rwd),
        .rsp_rdata(rdat), .rsp_err(rerr), .irq(irq)
    );

    tick_timer #(.HAS_REF(1'b0)) uut_noref (
        .clk(clk), .rst_n(rst_n), .ref_tick(1'b0),
        .req_valid(nv), .req_write(nw), .req_user(1'b0), .req_addr(na), .req_wdata(nwd),
        .rsp_rdata(ndat), .rsp_err(nerr_o), .irq(nirq)
    );

    typedef struct packed {
        logic        usr;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h00, 32'h0,         32'h0000_0000, 1'b0, 4'd1 },  // R1
        '{1'b0, 1'b0, 8'h04, 32'h0,         32'h0000_0000, 1'b0, 4'd1 },  // R1
        '{1'b0, 1'b0, 8'h08, 32'h0,         32'h0000_0000, 1'b0, 4'd1 },  // R1
        '{1'b0, 1'b0, 8'h0C, 32'h0,         32'h0001_869F, 1'b0, 4'd11},  // R11
        '{1'b0, 1'b1, 8'h0C, 32'h1234_5678, 32'h0000_0000, 1'b0, 4'd11},  // R11
        '{1'b0, 1'b0, 8'h0C, 32'h0,         32'h0001_869F, 1'b0, 4'd11},  // R11
        '{1'b0, 1'b1, 8'h04, 32'hAB12_3456, 32'h0000_0000, 1'b0, 4'd7 },  // R7
        '{1'b0, 1'b0, 8'h04, 32'h0,         32'h0012_3456, 1'b0, 4'd7 },  // R7
        '{1'b1, 1'b1, 8'h04, 32'h0000_0077, 32'h0000_0000, 1'b1, 4'd12},  // R12
        '{1'b0, 1'b0, 8'h04, 32'h0,         32'h0012_3456, 1'b0, 4'd12},  // R12
        '{1'b1, 1'b0, 8'h0C, 32'h0,         32'h0000_0000, 1'b1, 4'd12},  // R12
        '{1'b0, 1'b1, 8'h10, 32'h0000_0055, 32'h0000_0000, 1'b0, 4'd13},  // R13
        '{1'b0, 1'b0, 8'h10, 32'h0,         32'h0000_0000, 1'b0, 4'd13},  // R13
        '{1'b0, 1'b0, 8'h04, 32'h0,         32'h0012_3456, 1'b0, 4'd13},  // R13
        '{1'b0, 1'b1, 8'h00, 32'hFFFF_FFFA, 32'h0000_0000, 1'b0, 4'd2 },  // R2
        '{1'b0, 1'b0, 8'h00, 32'h0,         32'h0000_0002, 1'b0, 4'd2 }   // R2
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle: called at a falling edge, returns at the next falling edge
    task automatic acc(input logic u, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic rt,
                       output logic [31:0] rd, output logic er);
        rv = 1'b1; ru = u; rw = w; ra = a; rwd = d; ref_tick = rt;
        #1;
        rd = rdat; er = rerr;
        @(negedge clk);
        rv = 1'b0; ru = 1'b0; rw = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] x; logic e;
        acc(1'b0, 1'b1, a, d, 1'b0, x, e);
    endtask

    task automatic rd_chk(input int req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] x; logic e;
        acc(1'b0, 1'b0, a, 32'h0, 1'b0, x, e);
        check(req, x, exp);
    endtask

    task automatic pulse();
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] x; logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, {31'b0, irq}, 32'h0);                    // R1

        // R10: build without reference
        nv = 1'b1; na = 8'h00; #1;
        check(10, ndat, 32'h4);                           // R10
        nw = 1'b1; nwd = 32'h0; @(negedge clk); nw = 1'b0; #1;
        check(10, ndat, 32'h4);                           // R10
        na = 8'h0C; #1;
        check(11, ndat, 32'h8000_0000);                   // R11
        @(negedge clk); nv = 1'b0;

        for (int i = 0; i < NV; i++) begin
            acc(VECS[i].usr, VECS[i].wr, VECS[i].addr, VECS[i].wd, 1'b0, x, e);
            check(int'(VECS[i].req), x, VECS[i].exp);
            check(int'(VECS[i].req), {31'b0, e}, {31'b0, VECS[i].eerr});
        end
        wr(8'h00, 32'h0);

        // R14 / R3 / R5: enable and switch to core clock in one write
        wr(8'h04, 32'd3);
        wr(8'h00, 32'h7);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            check(((k % 4) == 0) ? 5 : 14, {31'b0, irq}, {31'b0, ((k % 4) == 0)});   // R5 R14
        end
        acc(1'b0, 1'b0, 8'h08, 32'h0, 1'b0, x, e);
        check(4, x, 32'd3);                               // R4 period reload+1
        wr(8'h00, 32'h0);
        rd_chk(6, 8'h00, 32'h0001_0000);                  // R6 flag returned
        rd_chk(6, 8'h00, 32'h0000_0000);                  // R6 flag cleared

        // R5: interrupt disabled, no pulse
        wr(8'h00, 32'h5);
        for (int k = 0; k < 10; k++) begin
            check(5, {31'b0, irq}, 32'h0);                // R5
            @(negedge clk);
        end
        wr(8'h00, 32'h0);
        wr(8'h08, 32'hDEAD_BEEF);
        rd_chk(8, 8'h00, 32'h0);                          // R8 flag cleared
        rd_chk(8, 8'h08, 32'h0);                          // R8 count zeroed

        // R3: reference strobe source
        wr(8'h04, 32'd2);
        wr(8'h00, 32'h3);
        repeat (5) @(negedge clk);
        rd_chk(3, 8'h08, 32'h0);                          // R3 no strobe, no count
        pulse();
        rd_chk(3, 8'h08, 32'd2);                          // R3 R4 load on strobe
        pulse();
        rd_chk(4, 8'h08, 32'd1);                          // R4
        rd_chk(6, 8'h00, 32'h3);

        // R6: expiry and clearing read in one cycle
        acc(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, x, e);
        check(6, x, 32'h3);                               // R6 old flag returned
        check(5, {31'b0, irq}, 32'h1);                    // R5
        rd_chk(6, 8'h00, 32'h0001_0003);                  // R6 expiry survived
        rd_chk(6, 8'h00, 32'h0000_0003);

        // R8: count write against same-cycle expiry
        pulse(); pulse();
        acc(1'b0, 1'b1, 8'h08, 32'h1, 1'b1, x, e);
        check(8, {31'b0, irq}, 32'h0);                    // R8 no pulse
        rd_chk(8, 8'h08, 32'h0);                          // R8
        rd_chk(8, 8'h00, 32'h3);                          // R8 no flag

        // R9: zero reload halts
        pulse();
        wr(8'h04, 32'd0);
        pulse(); pulse();
        wr(8'h04, 32'd5);
        pulse(); pulse();
        rd_chk(9, 8'h08, 32'h0);                          // R9 halted
        rd_chk(9, 8'h00, 32'h0001_0003);                  // R9 enable still 1
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h3);
        pulse();
        rd_chk(9, 8'h08, 32'd5);                          // R9 restarted

        finish_run();
    end

endmodule